// File: doc/BRIEF.md
# Hazard-Safe Read-Priority Reorderer

This block takes the pending commands that target one memory rank and puts them in a new order. Reads go as early as possible, and no read ever overtakes an older write to the same location. The commands of one set are loaded in arrival order. Each command carries a read/write flag and an address. After the set is closed, the block emits every command once, one per clock, in the order in which it should enter that rank's FIFO command queue. A position nearer the front means higher priority.

The emission rule works through the reads from oldest to youngest. Before each read, the block first emits every older write that has not yet been emitted and whose compared address bits equal the read's, oldest first. It then emits the read. Once no reads are left, it emits whatever remains in arrival order. The number of low address bits that take part in the comparison is a parameter. A narrow comparator produces false matches, which only pull extra writes forward, so it can never create a hazard.

Top module: `rw_group_reorder`

## Requirements
- R1: After reset, and whenever no set is being emitted, `in_ready` is 1 and `out_valid` is 0. A beat with `in_valid` and `in_ready` both high stores one command. The set closes when a stored beat has `in_last`=1, or when the DEPTH-th command is stored. Emission begins in the next cycle.
- R2: During emission, `out_valid` stays 1 for exactly as many consecutive cycles as there were stored commands. Every stored command appears exactly once. `out_last` is 1 only on the final beat. In the cycle after that beat, `out_valid` is 0 and `in_ready` is 1. While `out_valid` is 1, `in_ready` is 0.
- R3: Reads are emitted in their arrival order.
- R4: Just before each read, the block emits every older write that has not yet been emitted and whose compared address bits equal the read's. These writes come in arrival order, with nothing else between them and the read.
- R5: A read with no such pending older write is emitted immediately after the preceding group. It forms a group of one.
- R6: After the last read, the commands that remain are emitted in arrival order. A set without reads therefore comes out unchanged.
- R7: Only the low CMP_BITS address bits are compared. A write that differs from a read only in higher bits still counts as a match. A write that comes after a read is never moved ahead of it.
- R8: `out_tag` is the arrival index of the emitted command, counting from 0 for the first stored command. `out_read` and `out_addr` are that command's stored flag (1 = read) and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command offered for the set |
| in_read | input | 1 | 1 = read, 0 = write |
| in_addr | input | AW | Command address |
| in_last | input | 1 | Offered command closes the set |
| in_ready | output | 1 | Set is open for loading |
| out_valid | output | 1 | Emitted command valid |
| out_read | output | 1 | Emitted command is a read |
| out_addr | output | AW | Emitted command address |
| out_tag | output | $clog2(DEPTH) | Arrival index of emitted command |
| out_last | output | 1 | Final command of the set |

## Verification
The bound checker looks at every cycle. It checks that loading and emission never overlap, and that no arrival index is emitted twice or falls outside the stored count. It also checks that reads leave in rising arrival order, and that no read is emitted while an older write to the same full address is still pending. That last check is the hazard rule itself. Only the bench scenarios can show the exact grouped order, because the same stimulus is compared against a model under both a full and a two-bit comparator. The same applies to conservative matching through aliased addresses, to a read placed ahead of a younger same-address write, and to the automatic close of a full set.

// File: rtl/rw_group_reorder.sv
module rw_group_reorder #(
  parameter int DEPTH    = 8,
  parameter int AW       = 8,
  parameter int CMP_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_read,
  input  logic [AW-1:0]            in_addr,
  input  logic                     in_last,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic                     out_read,
  output logic [AW-1:0]            out_addr,
  output logic [$clog2(DEPTH)-1:0] out_tag,
  output logic                     out_last
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam int CB = (CMP_BITS < 1) ? 1 : ((CMP_BITS > AW) ? AW : CMP_BITS);

  logic          slot_rd [DEPTH];
  logic [AW-1:0] slot_ad [DEPTH];
  logic [DEPTH-1:0] pend;
  logic [CW-1:0] fill;
  logic          emitting;

  logic          rd_hit, wr_hit, any_hit;
  logic [IW-1:0] rd_idx, wr_idx, any_idx, sel;
  logic          accept, close_set;

  assign in_ready  = !emitting;
  assign out_valid = emitting;
  assign accept    = in_valid && in_ready;
  assign close_set = in_last || (fill == CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (accept) begin
      slot_rd[fill[IW-1:0]] <= in_read;
      slot_ad[fill[IW-1:0]] <= in_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitting <= 1'b0;
      fill     <= '0;
      pend     <= '0;
    end else if (accept) begin
      pend[fill[IW-1:0]] <= 1'b1;
      if (close_set) begin
        emitting <= 1'b1;
        fill     <= '0;
      end else begin
        fill <= fill + CW'(1);
      end
    end else if (emitting) begin
      pend[sel] <= 1'b0;
      if (out_last) emitting <= 1'b0;
    end
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_idx  = '0;
    any_hit = 1'b0;
    any_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (pend[i] && slot_rd[i]) begin
        rd_hit = 1'b1;
        rd_idx = IW'(i);
      end
      if (pend[i]) begin
        any_hit = 1'b1;
        any_idx = IW'(i);
      end
    end
  end

  always_comb begin
    wr_hit = 1'b0;
    wr_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (pend[i] && !slot_rd[i] && (IW'(i) < rd_idx) &&
          (slot_ad[i][CB-1:0] == slot_ad[rd_idx][CB-1:0])) begin
        wr_hit = 1'b1;
        wr_idx = IW'(i);
      end
    end
  end

  assign sel      = rd_hit ? (wr_hit ? wr_idx : rd_idx) : any_idx;
  assign out_read = slot_rd[sel];
  assign out_addr = slot_ad[sel];
  assign out_tag  = sel;
  assign out_last = emitting && any_hit && ($countones(pend) == 1);
endmodule

// File: rtl/rw_group_reorder_chk.sv
module rw_group_reorder_chk #(
  parameter int DEPTH    = 8,
  parameter int AW       = 8,
  parameter int CMP_BITS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_read,
  input logic [AW-1:0]            in_addr,
  input logic                     in_last,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_read,
  input logic [AW-1:0]            out_addr,
  input logic [$clog2(DEPTH)-1:0] out_tag,
  input logic                     out_last
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  logic             c_rd [DEPTH];
  logic [AW-1:0]    c_ad [DEPTH];
  logic [CW-1:0]    c_fill;
  logic [DEPTH-1:0] seen;
  logic [IW-1:0]    last_rd;
  logic             have_rd;
  logic             hz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_fill  <= '0;
      seen    <= '0;
      have_rd <= 1'b0;
      last_rd <= '0;
    end else begin
      if (in_valid && in_ready) begin
        c_rd[c_fill[IW-1:0]] <= in_read;
        c_ad[c_fill[IW-1:0]] <= in_addr;
        c_fill <= c_fill + CW'(1);
      end
      if (out_valid) begin
        seen[out_tag] <= 1'b1;
        if (out_read) begin
          have_rd <= 1'b1;
          last_rd <= out_tag;
        end
        if (out_last) begin
          c_fill  <= '0;
          seen    <= '0;
          have_rd <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    hz = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if ((IW'(k) < out_tag) && (CW'(k) < c_fill) && !c_rd[k] &&
          (c_ad[k] == out_addr) && !seen[k])
        hz = 1'b1;
  end

  a_r2_no_load_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r1_close_starts_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> out_valid);
  a_r2_once_each: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !seen[out_tag]);
  a_r8_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CW'(out_tag) < c_fill));
  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> (!out_valid && in_ready));
  a_r3_read_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_read && have_rd) |-> (out_tag > last_rd));
  a_r4_no_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_read) |-> !hz);
endmodule

bind rw_group_reorder rw_group_reorder_chk #(
  .DEPTH(DEPTH), .AW(AW), .CMP_BITS(CMP_BITS)
) u_chk (.*);

// File: tb/rw_group_reorder_tb.sv
`timescale 1ns/1ps
module rw_group_reorder_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 8;
  localparam int IW    = $clog2(DEPTH);
  typedef int iq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_read = 1'b0, in_last = 1'b0;
  logic [AW-1:0] in_addr = '0;

  logic rdy_i, ov_i, ord_i, ol_i, rdy_n, ov_n, ord_n, ol_n;
  logic [AW-1:0] oa_i, oa_n;
  logic [IW-1:0] ot_i, ot_n;

  int tests = 0, fails = 0;
  bit done = 0;
  bit rd [DEPTH];
  int ad [DEPTH];

  always #4 clk = ~clk;

  rw_group_reorder #(.DEPTH(DEPTH), .AW(AW), .CMP_BITS(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_read(in_read),
    .in_addr(in_addr), .in_last(in_last), .in_ready(rdy_i), .out_valid(ov_i),
    .out_read(ord_i), .out_addr(oa_i), .out_tag(ot_i), .out_last(ol_i));

  rw_group_reorder #(.DEPTH(DEPTH), .AW(AW), .CMP_BITS(2)) dut_n (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_read(in_read),
    .in_addr(in_addr), .in_last(in_last), .in_ready(rdy_n), .out_valid(ov_n),
    .out_read(ord_n), .out_addr(oa_n), .out_tag(ot_n), .out_last(ol_n));

  task automatic chk(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic iq_t build(int n, int cb);
    iq_t q;
    bit used [DEPTH];
    int mask = (1 << cb) - 1;
    for (int j = 0; j < n; j++) used[j] = 0;
    for (int j = 0; j < n; j++)
      if (rd[j]) begin
        for (int k = 0; k < j; k++)
          if (!used[k] && ((ad[k] & mask) == (ad[j] & mask))) begin
            q.push_back(k);
            used[k] = 1;
          end
        q.push_back(j);
        used[j] = 1;
      end
    for (int j = 0; j < n; j++)
      if (!used[j]) q.push_back(j);
    return q;
  endfunction

  task automatic put(int i, bit r, int a);
    rd[i] = r;
    ad[i] = a;
  endtask

  task automatic run_set(int n, bit use_last, string req);
    iq_t ef, en;
    ef = build(n, AW);
    en = build(n, 2);
    @(negedge clk);
    chk(rdy_i && rdy_n && !ov_i && !ov_n, "R1", "idle ready", int'(rdy_i), 1);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_read  = rd[i];
      in_addr  = AW'(ad[i]);
      in_last  = use_last && (i == n - 1);
      @(negedge clk);
      if (i < n - 1) chk(!ov_i && rdy_i, "R1", "still loading", int'(ov_i), 0);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int b = 0; b < n; b++) begin
      chk(ov_i && !rdy_i && int'(ot_i) == ef[b] && ord_i == rd[ef[b]] &&
          int'(oa_i) == ad[ef[b]] && ol_i == (b == n - 1),
          req, $sformatf("full cmp beat %0d tag", b), int'(ot_i), ef[b]);
      chk(ov_n && int'(ot_n) == en[b] && ord_n == rd[en[b]] &&
          int'(oa_n) == ad[en[b]] && ol_n == (b == n - 1),
          req, $sformatf("narrow cmp beat %0d tag", b), int'(ot_n), en[b]);
      @(negedge clk);
    end
    chk(!ov_i && !ov_n && rdy_i && rdy_n, "R2", "set ended", int'(ov_i), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ov_i && rdy_i, "R1", "reset out_valid", int'(ov_i), 0);
    rst_n = 1'b1;

    // R4 R3 R6 R1: grouped example, full set closes without in_last
    put(0,0,8'h11); put(1,0,8'h22); put(2,0,8'h33); put(3,0,8'h22);
    put(4,1,8'h22); put(5,1,8'h33); put(6,0,8'h44); put(7,0,8'h55);
    run_set(8, 0, "R4");

    // R6: writes only, FIFO
    put(0,0,8'h01); put(1,0,8'h02); put(2,0,8'h01); put(3,0,8'h07);
    run_set(4, 1, "R6");

    // R3 R5: reads only
    put(0,1,8'h10); put(1,1,8'h10); put(2,1,8'h21); put(3,1,8'h33); put(4,1,8'h02);
    run_set(5, 1, "R3");

    // R5 R8: single read
    put(0,1,8'h9A);
    run_set(1, 1, "R8");

    // R7: younger write to same address stays behind the read
    put(0,1,8'h40); put(1,0,8'h40); put(2,0,8'h41);
    run_set(3, 1, "R7");

    // R7: alias only in low bits (0x05 vs 0x01) pulls the write for the narrow comparator
    put(0,0,8'h05); put(1,1,8'h01); put(2,0,8'h03);
    run_set(3, 1, "R7");

    // R4 R5: repeated address with interleaved reads and writes
    put(0,0,8'h0C); put(1,1,8'h0C); put(2,0,8'h0C); put(3,0,8'h0D);
    put(4,1,8'h0C); put(5,1,8'h0E);
    run_set(6, 1, "R5");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule